// File: doc/BRIEF.md
# Ping-Pong Operand Memory with Bus Formatter

This block is the local data store for an 8×8 array of compute cells. It holds two identical sets of storage, and each set has two banks (A and B) of 64 rows of 8 bytes. At any time one set belongs to the array and the other to a bulk-transfer (DMA) port. When a producer has finished filling the idle set and the array has finished with the busy one, a single swap request exchanges their roles. Fresh data can therefore stream in while the array computes.

On the array side, a read fetches one row from each bank of the active set. The two rows are arranged onto a 128-bit operand bus that is split into eight 16-bit segments, one segment per array row. The bytes are either interleaved (each cell receives one byte from each bank) or contiguous (bank A fills the low half of the bus and bank B the high half). The two banks can be addressed separately, or in unified mode one start address selects the same row in both banks. Results return on a 128-bit result bus. In 8-bit mode the low byte of each cell forms one 8-byte row for a chosen bank. In 16-bit mode the first four cells fill a bank A row and the last four fill a bank B row.

Top module: `fb_pingpong`

## Requirements
- R1: After reset, sel_o is 0 (the array owns set 0, the DMA port owns set 1), opnd_vld_o and dma_vld_o are 0, and opnd_o and dma_rdata_o are all zero.
- R2: The DMA port always works on the set not selected by sel_o. dma_bank_i picks the bank (0 = A, 1 = B) and dma_addr_i picks the row. A write stores all 8 bytes of dma_wdata_i. A read returns the row on dma_rdata_o with dma_vld_o high exactly one cycle after the request.
- R3: An array read (ar_en_i) takes both bank rows from the set selected by sel_o. The formatted bus appears on opnd_o with opnd_vld_o high exactly one cycle later, and opnd_vld_o is low in every other cycle.
- R4: In separate mode (ar_unified_i = 0), the bank A row comes from ar_addr_a_i and the bank B row comes from ar_addr_b_i.
- R5: In unified mode (ar_unified_i = 1), both banks use row ar_addr_a_i and ar_addr_b_i has no effect on opnd_o.
- R6: With ar_order_i = 0 (interleaved), bus byte 2n holds bank A byte n and bus byte 2n+1 holds bank B byte n, for n = 0..7. Bus byte k occupies opnd_o[8k+7:8k], so cell r's segment opnd_o[16r+15:16r] carries A byte r in its low half and B byte r in its high half.
- R7: With ar_order_i = 1 (contiguous), opnd_o[63:0] is the bank A row and opnd_o[127:64] is the bank B row.
- R8: A result write with wr_mode16_i = 0 stores, into row wr_addr_i of bank wr_bank_i (0 = A, 1 = B) of the active set, a row whose byte n is res_i[16n+7:16n]. The other bank's row is left unchanged.
- R9: A result write with wr_mode16_i = 1 stores res_i[63:0] (cells 0 to 3) into row wr_addr_i of bank A and res_i[127:64] (cells 4 to 7) into the same row of bank B, both in the active set.
- R10: A swap_req_i pulse toggles sel_o on the next edge only when that cycle has no ar_en_i, wr_en_i or dma_en_i and neither opnd_vld_o nor dma_vld_o is high. Otherwise the request is ignored and is not held over.
- R11: DMA and array accesses in the same cycle go to their own sets and do not disturb each other's data or results.
- R12: An array read and a result write to the same row in the same cycle return the row's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swap_req_i | input | 1 | Request to exchange set ownership |
| sel_o | output | 1 | Set currently owned by the array |
| ar_en_i | input | 1 | Array operand read strobe |
| ar_unified_i | input | 1 | 1 = both banks use ar_addr_a_i |
| ar_order_i | input | 1 | 0 = interleaved, 1 = contiguous |
| ar_addr_a_i | input | 6 | Bank A row (start row in unified mode) |
| ar_addr_b_i | input | 6 | Bank B row in separate mode |
| opnd_o | output | 128 | Formatted operand bus |
| opnd_vld_o | output | 1 | opnd_o holds read data |
| wr_en_i | input | 1 | Result write strobe |
| wr_mode16_i | input | 1 | 1 = 16-bit result split, 0 = 8-bit |
| wr_bank_i | input | 1 | Target bank in 8-bit mode |
| wr_addr_i | input | 6 | Result row |
| res_i | input | 128 | Result bus, 16 bits per cell |
| dma_en_i | input | 1 | DMA access strobe |
| dma_we_i | input | 1 | 1 = write, 0 = read |
| dma_bank_i | input | 1 | DMA bank select |
| dma_addr_i | input | 6 | DMA row |
| dma_wdata_i | input | 64 | DMA write row |
| dma_rdata_o | output | 64 | DMA read row |
| dma_vld_o | output | 1 | dma_rdata_o holds read data |

## Verification
The bench fills both sets through the DMA port with a pattern that depends on set, bank, row and lane. It then reads every row in all four combinations of order and addressing mode. A byte swap in the formatter, or a B address that leaks into unified mode, therefore shows up as a wrong byte at a known bus position. It writes results in both modes and then reads back both banks. An 8-bit write that touches the other bank, or a 16-bit split that crosses at the wrong cell, changes a row that should be intact. It issues swap requests during an access and in the cycle after a read, where a design that queues the request or ignores the pending result would move sel_o too early. It also issues same-cycle DMA/array traffic and same-row read/write pairs, which catch cross-set writes and write-first read paths.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_CONTIG     = 1'b1
  } ord_e;

  typedef enum logic {
    RES_8B  = 1'b0,
    RES_16B = 1'b1
  } res_mode_e;
endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned LANES = 8,
  localparam int unsigned AW   = $clog2(ROWS),
  localparam int unsigned BW   = LANES * fb_pkg::BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [BW-1:0]    wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [BW-1:0]    rdata_o
);
  localparam int unsigned BYW = fb_pkg::BYTE_W;

  logic [BW-1:0] mem_q [ROWS];
  logic [BW-1:0] rdata_q;

  // per-lane write enables
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < int'(LANES); l++) begin
        if (be_i[l]) mem_q[waddr_i][l*BYW +: BYW] <= wdata_i[l*BYW +: BYW];
      end
    end
  end

  // registered read, old data on same-row collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

  assert_rd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/fb_opnd_fmt.sv
module fb_opnd_fmt #(
  parameter int unsigned LANES = 8,
  localparam int unsigned BW   = LANES * fb_pkg::BYTE_W
) (
  input  logic          ord_i,
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [2*BW-1:0] bus_o
);
  localparam int unsigned BYW = fb_pkg::BYTE_W;

  logic [2*BW-1:0] ilv;

  for (genvar n = 0; n < int'(LANES); n++) begin : g_ilv
    assign ilv[2*n*BYW     +: BYW] = a_i[n*BYW +: BYW];
    assign ilv[(2*n+1)*BYW +: BYW] = b_i[n*BYW +: BYW];
  end

  assign bus_o = (ord_i == fb_pkg::ORD_CONTIG) ? {b_i, a_i} : ilv;
endmodule

// File: rtl/fb_res_fmt.sv
module fb_res_fmt #(
  parameter int unsigned LANES = 8,
  localparam int unsigned BW   = LANES * fb_pkg::BYTE_W
) (
  input  logic                  en_i,
  input  logic                  mode_i,
  input  logic                  bank_i,
  input  logic [2*BW-1:0]       res_i,
  output logic [1:0]            we_o,
  output logic [1:0][LANES-1:0] be_o,
  output logic [1:0][BW-1:0]    data_o
);
  localparam int unsigned BYW = fb_pkg::BYTE_W;

  logic [BW-1:0] narrow;

  // low byte of each cell segment
  for (genvar n = 0; n < int'(LANES); n++) begin : g_nar
    assign narrow[n*BYW +: BYW] = res_i[2*n*BYW +: BYW];
  end

  always_comb begin
    we_o   = '0;
    be_o   = '0;
    data_o = '0;
    if (mode_i == fb_pkg::RES_16B) begin
      data_o[0] = res_i[BW-1:0];
      data_o[1] = res_i[2*BW-1:BW];
      we_o      = {2{en_i}};
      be_o[0]   = {LANES{en_i}};
      be_o[1]   = {LANES{en_i}};
    end else begin
      data_o[0]      = narrow;
      data_o[1]      = narrow;
      we_o[bank_i]   = en_i;
      be_o[bank_i]   = {LANES{en_i}};
    end
  end
endmodule

// File: rtl/fb_pingpong.sv
module fb_pingpong #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned LANES = 8,
  localparam int unsigned AW   = $clog2(ROWS),
  localparam int unsigned BW   = LANES * fb_pkg::BYTE_W,
  localparam int unsigned OPW  = 2 * BW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           swap_req_i,
  output logic           sel_o,
  input  logic           ar_en_i,
  input  logic           ar_unified_i,
  input  logic           ar_order_i,
  input  logic [AW-1:0]  ar_addr_a_i,
  input  logic [AW-1:0]  ar_addr_b_i,
  output logic [OPW-1:0] opnd_o,
  output logic           opnd_vld_o,
  input  logic           wr_en_i,
  input  logic           wr_mode16_i,
  input  logic           wr_bank_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [OPW-1:0] res_i,
  input  logic           dma_en_i,
  input  logic           dma_we_i,
  input  logic           dma_bank_i,
  input  logic [AW-1:0]  dma_addr_i,
  input  logic [BW-1:0]  dma_wdata_i,
  output logic [BW-1:0]  dma_rdata_o,
  output logic           dma_vld_o
);
  logic sel_q, ar_pend_q, dma_pend_q, dma_bank_q, ord_q;
  logic busy, swap_go;
  logic [AW-1:0] addr_b_eff;

  logic [1:0]            res_we;
  logic [1:0][LANES-1:0] res_be;
  logic [1:0][BW-1:0]    res_data;

  logic [BW-1:0] rdata [2][2];

  assign busy    = ar_en_i | wr_en_i | dma_en_i | ar_pend_q | dma_pend_q;
  assign swap_go = swap_req_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= 1'b0;
      ar_pend_q  <= 1'b0;
      dma_pend_q <= 1'b0;
      dma_bank_q <= 1'b0;
      ord_q      <= 1'b0;
    end else begin
      if (swap_go) sel_q <= ~sel_q;
      ar_pend_q  <= ar_en_i;
      dma_pend_q <= dma_en_i & ~dma_we_i;
      if (dma_en_i & ~dma_we_i) dma_bank_q <= dma_bank_i;
      if (ar_en_i) ord_q <= ar_order_i;
    end
  end

  assign addr_b_eff = ar_unified_i ? ar_addr_a_i : ar_addr_b_i;

  fb_res_fmt #(.LANES(LANES)) u_res_fmt (
    .en_i   (wr_en_i),
    .mode_i (wr_mode16_i),
    .bank_i (wr_bank_i),
    .res_i  (res_i),
    .we_o   (res_we),
    .be_o   (res_be),
    .data_o (res_data)
  );

  for (genvar s = 0; s < 2; s++) begin : g_set
    logic arr_side;
    assign arr_side = (sel_q == 1'(s));
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic dma_hit;
      logic [AW-1:0] arr_raddr;
      assign dma_hit   = dma_en_i & (dma_bank_i == 1'(b));
      assign arr_raddr = (b == 0) ? ar_addr_a_i : addr_b_eff;
      fb_bank #(.ROWS(ROWS), .LANES(LANES)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (arr_side ? res_we[b] : (dma_hit & dma_we_i)),
        .be_i    (arr_side ? res_be[b] : {LANES{1'b1}}),
        .waddr_i (arr_side ? wr_addr_i : dma_addr_i),
        .wdata_i (arr_side ? res_data[b] : dma_wdata_i),
        .re_i    (arr_side ? ar_en_i : (dma_hit & ~dma_we_i)),
        .raddr_i (arr_side ? arr_raddr : dma_addr_i),
        .rdata_o (rdata[s][b])
      );
    end
  end

  fb_opnd_fmt #(.LANES(LANES)) u_opnd_fmt (
    .ord_i (ord_q),
    .a_i   (rdata[sel_q][0]),
    .b_i   (rdata[sel_q][1]),
    .bus_o (opnd_o)
  );

  assign sel_o       = sel_q;
  assign opnd_vld_o  = ar_pend_q;
  assign dma_rdata_o = rdata[~sel_q][dma_bank_q];
  assign dma_vld_o   = dma_pend_q;

  assert_swap_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_req_i |=> $stable(sel_o));
  assert_swap_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_req_i && (ar_en_i || wr_en_i || dma_en_i || opnd_vld_o || dma_vld_o)) |=> $stable(sel_o));
  assert_swap_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_req_i && !ar_en_i && !wr_en_i && !dma_en_i && !opnd_vld_o && !dma_vld_o)
      |=> (sel_o != $past(sel_o)));
  assert_opnd_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_en_i |=> opnd_vld_o);
  assert_opnd_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ar_en_i |=> !opnd_vld_o);
  assert_dma_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && !dma_we_i) |=> dma_vld_o);
  assert_res8_one_bank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_mode16_i) |-> $onehot(res_we));
  assert_res16_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_mode16_i) |-> (res_we == 2'b11));
endmodule

// File: tb/fb_pingpong_test.sv
module fb_pingpong_test;
  localparam int ROWS = 64;
  localparam int BW   = 64;
  localparam int OPW  = 128;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic           swap_req_i = 0, sel_o;
  logic           ar_en_i = 0, ar_unified_i = 0, ar_order_i = 0;
  logic [5:0]     ar_addr_a_i = 0, ar_addr_b_i = 0;
  logic [OPW-1:0] opnd_o;
  logic           opnd_vld_o;
  logic           wr_en_i = 0, wr_mode16_i = 0, wr_bank_i = 0;
  logic [5:0]     wr_addr_i = 0;
  logic [OPW-1:0] res_i = '0;
  logic           dma_en_i = 0, dma_we_i = 0, dma_bank_i = 0;
  logic [5:0]     dma_addr_i = 0;
  logic [BW-1:0]  dma_wdata_i = '0, dma_rdata_o;
  logic           dma_vld_o;

  fb_pingpong uut (
    .clk_i(clk), .rst_ni(rst_ni), .swap_req_i(swap_req_i), .sel_o(sel_o),
    .ar_en_i(ar_en_i), .ar_unified_i(ar_unified_i), .ar_order_i(ar_order_i),
    .ar_addr_a_i(ar_addr_a_i), .ar_addr_b_i(ar_addr_b_i),
    .opnd_o(opnd_o), .opnd_vld_o(opnd_vld_o),
    .wr_en_i(wr_en_i), .wr_mode16_i(wr_mode16_i), .wr_bank_i(wr_bank_i),
    .wr_addr_i(wr_addr_i), .res_i(res_i),
    .dma_en_i(dma_en_i), .dma_we_i(dma_we_i), .dma_bank_i(dma_bank_i),
    .dma_addr_i(dma_addr_i), .dma_wdata_i(dma_wdata_i),
    .dma_rdata_o(dma_rdata_o), .dma_vld_o(dma_vld_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [BW-1:0] mdl [2][2][ROWS];
  logic msel = 0;

  function automatic logic [BW-1:0] pat(int s, int b, int r);
    logic [BW-1:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = 8'((r*8 + k)*5 + s*101 + b*37 + 3);
    return v;
  endfunction

  function automatic logic [OPW-1:0] fmt(logic ord, logic [BW-1:0] a, logic [BW-1:0] b);
    logic [OPW-1:0] v;
    if (ord) v = {b, a};
    else for (int n = 0; n < 8; n++) begin
      v[16*n +: 8]     = a[8*n +: 8];
      v[16*n + 8 +: 8] = b[8*n +: 8];
    end
    return v;
  endfunction

  function automatic logic [BW-1:0] narrow(logic [OPW-1:0] r);
    logic [BW-1:0] v;
    for (int n = 0; n < 8; n++) v[8*n +: 8] = r[16*n +: 8];
    return v;
  endfunction

  task automatic chk(string req, logic [OPW-1:0] act, logic [OPW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dma_wr(logic b, int r, logic [BW-1:0] d);
    dma_en_i = 1; dma_we_i = 1; dma_bank_i = b; dma_addr_i = 6'(r); dma_wdata_i = d;
    @(negedge clk);
    dma_en_i = 0; dma_we_i = 0;
    mdl[~msel][b][r] = d;
  endtask

  task automatic dma_rd(logic b, int r, string req);
    dma_en_i = 1; dma_we_i = 0; dma_bank_i = b; dma_addr_i = 6'(r);
    @(negedge clk);
    dma_en_i = 0;
    chk(req, OPW'(dma_vld_o), OPW'(1'b1));
    chk(req, OPW'(dma_rdata_o), OPW'(mdl[~msel][b][r]));
  endtask

  task automatic arr_rd(logic ord, logic uni, int aa, int ab, string req);
    logic [OPW-1:0] exp;
    ar_en_i = 1; ar_order_i = ord; ar_unified_i = uni;
    ar_addr_a_i = 6'(aa); ar_addr_b_i = 6'(ab);
    @(negedge clk);
    ar_en_i = 0;
    exp = fmt(ord, mdl[msel][0][aa], mdl[msel][1][uni ? aa : ab]);
    chk(req, OPW'(opnd_vld_o), OPW'(1'b1));
    chk(req, opnd_o, exp);
  endtask

  task automatic arr_wr(logic m16, logic b, int r, logic [OPW-1:0] res);
    wr_en_i = 1; wr_mode16_i = m16; wr_bank_i = b; wr_addr_i = 6'(r); res_i = res;
    @(negedge clk);
    wr_en_i = 0;
    if (m16) begin
      mdl[msel][0][r] = res[63:0];
      mdl[msel][1][r] = res[127:64];
    end else mdl[msel][b][r] = narrow(res);
  endtask

  task automatic swap_try(bit take, string req);
    swap_req_i = 1;
    @(negedge clk);
    swap_req_i = 0;
    if (take) msel = ~msel;
    chk(req, OPW'(sel_o), OPW'(msel));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", OPW'(sel_o), '0);
    chk("R1", OPW'(opnd_vld_o), '0);
    chk("R1", OPW'(dma_vld_o), '0);
    chk("R1", opnd_o, '0);
    chk("R1", OPW'(dma_rdata_o), '0);
    rst_ni = 1;
    @(negedge clk);

    // R2 fill idle set 1 and read it all back
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < 2; b++) dma_wr(1'(b), r, pat(1, b, r));
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < 2; b++) dma_rd(1'(b), r, "R2");

    @(negedge clk);
    swap_try(1, "R10");

    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < 2; b++) dma_wr(1'(b), r, pat(0, b, r));
    dma_rd(0, 0, "R2");
    dma_rd(1, 63, "R2");

    // R3 R4 R5 R6 R7 sweep over set 1
    for (int r = 0; r < ROWS; r++) begin
      arr_rd(0, 0, r, 63 - r, "R4 R6");
      arr_rd(1, 1, r, (r*7 + 3) % 64, "R5 R7");
      arr_rd(1, 0, r, (r + 17) % 64, "R4 R7");
      arr_rd(0, 1, r, (r*11 + 5) % 64, "R5 R6");
    end

    // R8 8-bit writes, R9 16-bit writes
    arr_wr(0, 0, 5, {8{16'hA55A}} ^ 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    arr_wr(0, 1, 6, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    arr_wr(1, 0, 7, 128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_1234_5678);
    arr_rd(1, 0, 5, 5, "R8");
    arr_rd(1, 0, 6, 6, "R8");
    arr_rd(1, 0, 7, 7, "R9");
    for (int r = 20; r < 28; r++) begin
      arr_wr(1'(r % 3 == 0), 1'(r % 2), r, {4{32'(r * 32'h01020305)}});
      arr_rd(1, 0, r, r, (r % 3 == 0) ? "R9" : "R8");
    end

    // R11 DMA write idle set while array reads active set, same row
    dma_en_i = 1; dma_we_i = 1; dma_bank_i = 0; dma_addr_i = 10; dma_wdata_i = 64'hFACE_0FF1_CE00_BEEF;
    arr_rd(0, 1, 10, 0, "R11");
    dma_en_i = 0; dma_we_i = 0;
    mdl[~msel][0][10] = 64'hFACE_0FF1_CE00_BEEF;
    dma_rd(0, 10, "R11");
    arr_rd(0, 1, 10, 0, "R11");
    // R11 array write active set while DMA reads idle set, same row
    dma_en_i = 1; dma_we_i = 0; dma_bank_i = 1; dma_addr_i = 11;
    arr_wr(1, 0, 11, 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000_1111);
    dma_en_i = 0;
    chk("R11", OPW'(dma_rdata_o), OPW'(mdl[~msel][1][11]));
    arr_rd(1, 0, 11, 11, "R11");

    // R12 read and write same row same cycle
    begin
      logic [OPW-1:0] old_v;
      old_v = fmt(1, mdl[msel][0][12], mdl[msel][1][12]);
      wr_en_i = 1; wr_mode16_i = 1; wr_addr_i = 12; res_i = {8{16'h9C3E}};
      ar_en_i = 1; ar_order_i = 1; ar_unified_i = 1; ar_addr_a_i = 12;
      @(negedge clk);
      wr_en_i = 0; ar_en_i = 0;
      chk("R12", opnd_o, old_v);
      mdl[msel][0][12] = {4{16'h9C3E}};
      mdl[msel][1][12] = {4{16'h9C3E}};
      arr_rd(1, 1, 12, 0, "R12");
    end

    // R10 refused swaps
    @(negedge clk);
    ar_en_i = 1; ar_addr_a_i = 1;
    swap_try(0, "R10");
    ar_en_i = 0;
    swap_try(0, "R10");
    dma_en_i = 1; dma_we_i = 0; dma_addr_i = 2;
    swap_try(0, "R10");
    dma_en_i = 0;
    swap_try(0, "R10");
    wr_en_i = 1; wr_mode16_i = 0; wr_bank_i = 0; wr_addr_i = 30; res_i = '0;
    swap_try(0, "R10");
    wr_en_i = 0;
    mdl[msel][0][30] = '0;
    @(negedge clk);
    chk("R10", OPW'(sel_o), OPW'(msel));
    swap_try(1, "R10");

    // DMA now sees set 1 holding the array writes
    dma_rd(0, 5, "R8");
    dma_rd(1, 5, "R8");
    dma_rd(1, 6, "R8");
    dma_rd(0, 7, "R9");
    dma_rd(1, 7, "R9");
    dma_rd(0, 30, "R8");
    // array owns set 0 again
    arr_rd(0, 0, 0, 63, "R3");
    arr_rd(1, 1, 10, 0, "R3");
    @(negedge clk);
    chk("R3", OPW'(opnd_vld_o), '0);

    done = 1;
    summary();
    $finish;
  end
endmodule